// File: doc/BRIEF.md
# PCI Bus Even-Parity Generator and Checker

This block handles the parity bit of a 32-bit PCI agent. On the transmit side it takes the address/data and command/byte-enable values that the agent is about to drive, together with their output enable. One clock later it produces the matching parity bit and that bit's own output enable. Parity is even and always covers every AD and C/BE line, whether or not a byte lane carries useful data.

On the receive side it watches the bus. A check is armed on the cycle in which the frame signal goes active, which marks an address phase. A check is also armed on a data phase where both ready signals are active and the transfer targets this agent. The AD and C/BE values are captured on that cycle and compared with the parity bit seen on the next cycle. Any mismatch sets a sticky detected-parity-error flag. Software clears the flag by writing a one to it. All bus control inputs are active low.

Top module: `pci_parity_unit`

## Requirements
- R1: After each clock edge, `par_out` equals the XOR of all bits of `tx_ad` and `tx_cbe` sampled at that edge, so the ones across AD, C/BE and parity form an even count.
- R2: `par_oe` equals `tx_ad_oe` delayed by one clock, so parity stays enabled for one cycle after AD is released.
- R3: A cycle in which `frame_n` is 0 after being 1 on the previous cycle arms a check. If `bus_par` on the following cycle differs from the XOR of the captured `bus_ad` and `bus_cbe`, `perr_seen` is 1 after the next clock edge.
- R4: While `frame_n` stays 0 with no data transfer qualified, no check is armed, and a wrong `bus_par` leaves `perr_seen` at 0.
- R5: A cycle with `irdy_n`=0, `trdy_n`=0 and `tgt_hit`=1 arms a check with the same comparison and timing as R3.
- R6: A data cycle with `irdy_n`=1 or `trdy_n`=1 (a wait state) is never checked.
- R7: A completed data cycle with `tgt_hit`=0 is not checked.
- R8: `perr_seen` is sticky. Only a cycle with `stat_wr`=1 and `stat_w1c`=1 clears it. `stat_wr`=1 with `stat_w1c`=0, or `stat_w1c`=1 with `stat_wr`=0, has no effect.
- R9: When a mismatch and a clear land on the same clock edge, the flag ends up 1.
- R10: During reset, `par_out`, `par_oe` and `perr_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ad | input | 32 | AD value this agent drives |
| tx_cbe | input | 4 | C/BE value this agent drives |
| tx_ad_oe | input | 1 | This agent drives AD this cycle |
| par_out | output | 1 | Generated even parity, one cycle late |
| par_oe | output | 1 | Output enable for `par_out` |
| bus_ad | input | 32 | AD lines observed on the bus |
| bus_cbe | input | 4 | C/BE lines observed on the bus |
| bus_par | input | 1 | Parity line observed on the bus |
| frame_n | input | 1 | Frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| tgt_hit | input | 1 | The current transfer involves this agent |
| stat_wr | input | 1 | Status write strobe |
| stat_w1c | input | 1 | Write data bit for the status flag (1 clears) |
| perr_seen | output | 1 | Sticky detected-parity-error flag |

## Verification
The bench walks a single one through all 36 covered lines. A generator that dropped a C/BE bit or produced odd parity would get one of those positions wrong. It also sweeps all eight combinations of the two ready signals and the hit signal with deliberately wrong parity, so a checker that took wait states or foreign transfers would raise the flag where it must not. Address phases are tested both on the frame edge and while frame is held low, so that a level-qualified check shows up as a false error. Clear writes are tested with each strobe alone and on the same edge as a fresh mismatch, which would expose a lost error or a clear that fires on a partial write.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // transmit-side registered state
    typedef struct packed {
        logic par;
        logic oe;
    } gen_state_t;

    // receive-side registered state
    typedef struct packed {
        logic frame_n;  // frame line seen on the previous cycle
        logic pend;     // a check is armed for this cycle's parity
        logic exp;      // parity expected on this cycle
    } chk_state_t;

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen
    import pci_par_pkg::*;
#(
    parameter int AD_W = 32,
    localparam int BE_W = AD_W / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            ad_oe,
    output logic            par,
    output logic            par_oe
);

    gen_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.par = ^{ad, cbe};
        st_d.oe  = ad_oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par    = st_q.par;
    assign par_oe = st_q.oe;

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
    import pci_par_pkg::*;
#(
    parameter int AD_W = 32,
    localparam int BE_W = AD_W / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            par,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            trdy_n,
    input  logic            hit,
    output logic            pend,
    output logic            mismatch
);

    chk_state_t st_d, st_q;
    logic       addr_ph;
    logic       data_ph;

    always_comb begin
        addr_ph      = st_q.frame_n & ~frame_n;
        data_ph      = ~irdy_n & ~trdy_n & hit;
        st_d         = st_q;
        st_d.frame_n = frame_n;
        st_d.pend    = addr_ph | data_ph;
        st_d.exp     = ^{ad, cbe};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{frame_n: 1'b1, pend: 1'b0, exp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend     = st_q.pend;
    assign mismatch = st_q.pend & (par != st_q.exp);

endmodule

// File: rtl/pci_par_status.sv
module pci_par_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic w1c,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        // a new error outranks a clear on the same edge
        flag_d = set | (flag_q & ~(wr & w1c));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
    parameter int AD_W = 32,
    localparam int BE_W = AD_W / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] tx_ad,
    input  logic [BE_W-1:0] tx_cbe,
    input  logic            tx_ad_oe,
    output logic            par_out,
    output logic            par_oe,
    input  logic [AD_W-1:0] bus_ad,
    input  logic [BE_W-1:0] bus_cbe,
    input  logic            bus_par,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            trdy_n,
    input  logic            tgt_hit,
    input  logic            stat_wr,
    input  logic            stat_w1c,
    output logic            perr_seen
);

    logic chk_pend;
    logic chk_mismatch;

    pci_par_gen #(.AD_W(AD_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .ad     (tx_ad),
        .cbe    (tx_cbe),
        .ad_oe  (tx_ad_oe),
        .par    (par_out),
        .par_oe (par_oe)
    );

    pci_par_chk #(.AD_W(AD_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .ad       (bus_ad),
        .cbe      (bus_cbe),
        .par      (bus_par),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .trdy_n   (trdy_n),
        .hit      (tgt_hit),
        .pend     (chk_pend),
        .mismatch (chk_mismatch)
    );

    pci_par_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (chk_mismatch),
        .wr    (stat_wr),
        .w1c   (stat_w1c),
        .flag  (perr_seen)
    );

endmodule

// File: rtl/pci_par_sva.sv
module pci_par_sva #(
    parameter int AD_W = 32,
    localparam int BE_W = AD_W / 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AD_W-1:0] tx_ad,
    input logic [BE_W-1:0] tx_cbe,
    input logic            tx_ad_oe,
    input logic            par_out,
    input logic            par_oe,
    input logic            irdy_n,
    input logic            trdy_n,
    input logic            tgt_hit,
    input logic            stat_wr,
    input logic            stat_w1c,
    input logic            chk_pend,
    input logic            perr_seen
);

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (par_out == $past(^{tx_ad, tx_cbe}))); // R1

    AST_PAR_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (par_oe == $past(tx_ad_oe))); // R2

    AST_DATA_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !trdy_n && tgt_hit) |=> chk_pend); // R5

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_seen) |-> $past(chk_pend)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_seen && !(stat_wr && stat_w1c)) |=> perr_seen); // R8

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_w1c && !chk_pend) |=> !perr_seen); // R8

endmodule

bind pci_parity_unit pci_par_sva #(.AD_W(AD_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ad     (tx_ad),
    .tx_cbe    (tx_cbe),
    .tx_ad_oe  (tx_ad_oe),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .tgt_hit   (tgt_hit),
    .stat_wr   (stat_wr),
    .stat_w1c  (stat_w1c),
    .chk_pend  (chk_pend),
    .perr_seen (perr_seen)
);

// File: tb/test_pci_parity_unit.sv
module test_pci_parity_unit;

    localparam int AD_W = 32;
    localparam int BE_W = AD_W / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic            rst_n;
    logic [AD_W-1:0] tx_ad;
    logic [BE_W-1:0] tx_cbe;
    logic            tx_ad_oe;
    logic            par_out;
    logic            par_oe;
    logic [AD_W-1:0] bus_ad;
    logic [BE_W-1:0] bus_cbe;
    logic            bus_par;
    logic            frame_n;
    logic            irdy_n;
    logic            trdy_n;
    logic            tgt_hit;
    logic            stat_wr;
    logic            stat_w1c;
    logic            perr_seen;

    pci_parity_unit #(.AD_W(AD_W)) i_pci_parity_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_ad     (tx_ad),
        .tx_cbe    (tx_cbe),
        .tx_ad_oe  (tx_ad_oe),
        .par_out   (par_out),
        .par_oe    (par_oe),
        .bus_ad    (bus_ad),
        .bus_cbe   (bus_cbe),
        .bus_par   (bus_par),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .tgt_hit   (tgt_hit),
        .stat_wr   (stat_wr),
        .stat_w1c  (stat_w1c),
        .perr_seen (perr_seen)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic even_par(input logic [AD_W-1:0] a, input logic [BE_W-1:0] c);
        return ^{a, c};
    endfunction

    task automatic bus_idle();
        frame_n  = 1'b1;
        irdy_n   = 1'b1;
        trdy_n   = 1'b1;
        tgt_hit  = 1'b0;
        stat_wr  = 1'b0;
        stat_w1c = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        stat_wr  = 1'b1;
        stat_w1c = 1'b1;
        @(negedge clk);
        stat_wr  = 1'b0;
        stat_w1c = 1'b0;
        check("R8 clear", perr_seen, 0);
    endtask

    // one data cycle with the given qualifiers, then the parity cycle
    task automatic data_cycle(input logic [AD_W-1:0] a, input logic [BE_W-1:0] c,
                              input logic irdy, input logic trdy, input logic hit,
                              input logic bad, input logic exp_set, input string req);
        @(negedge clk);
        bus_ad  = a;
        bus_cbe = c;
        irdy_n  = irdy;
        trdy_n  = trdy;
        tgt_hit = hit;
        @(negedge clk);
        irdy_n  = 1'b1;
        trdy_n  = 1'b1;
        tgt_hit = 1'b0;
        bus_par = even_par(a, c) ^ bad;
        bus_ad  = ~a;
        @(negedge clk);
        check(req, perr_seen, exp_set);
        if (perr_seen) clear_flag();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AD_W-1:0] lfsr;
        rst_n    = 1'b0;
        bus_idle();
        tx_ad    = 32'h0000_0001;   // parity 1 while reset holds
        tx_cbe   = 4'h0;
        tx_ad_oe = 1'b1;
        bus_ad   = '0;
        bus_cbe  = '0;
        bus_par  = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 par_out", par_out, 0);
        check("R10 par_oe", par_oe, 0);
        check("R10 perr_seen", perr_seen, 0);
        tx_ad    = '0;
        tx_ad_oe = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: walking one over all 36 covered lines
        for (int i = 0; i < AD_W + BE_W; i++) begin
            logic [AD_W+BE_W-1:0] v;
            v        = '0;
            v[i]     = 1'b1;
            tx_ad    = v[AD_W-1:0];
            tx_cbe   = v[AD_W+BE_W-1:AD_W];
            tx_ad_oe = i[0];
            @(negedge clk);
            check("R1 walk", par_out, 1);
            check("R2 walk", par_oe, i[0]);
        end
        // R1: pseudo-random values, expected parity counted bit by bit
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 64; i++) begin
            int ones;
            lfsr     = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            tx_ad    = lfsr;
            tx_cbe   = lfsr[7:4] ^ 4'(i);
            tx_ad_oe = lfsr[9];
            ones     = $countones(tx_ad) + $countones(tx_cbe);
            @(negedge clk);
            check("R1 random", par_out, 32'(ones % 2));
            check("R2 random", par_oe, 32'(lfsr[9]));
        end
        // R2: parity enable stays one cycle after AD is released
        tx_ad_oe = 1'b0;
        @(negedge clk);
        check("R2 release", par_oe, 0);

        // R5/R6/R7: all qualifier combinations with wrong parity
        for (int k = 0; k < 8; k++) begin
            logic expset;
            expset = (k[0] == 1'b0) && (k[1] == 1'b0) && (k[2] == 1'b1);
            data_cycle(32'h1234_5678 ^ 32'(k), 4'(k), k[0], k[1], k[2], 1'b1, expset,
                       expset ? "R5 qualified" : (k[2] ? "R6 wait" : "R7 no hit"));
        end
        // R5: correct parity never flags, wrong parity always does
        for (int i = 0; i < AD_W + BE_W; i += 5) begin
            logic [AD_W+BE_W-1:0] v;
            v    = '0;
            v[i] = 1'b1;
            data_cycle(v[AD_W-1:0], v[AD_W+BE_W-1:AD_W], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 good");
            data_cycle(v[AD_W-1:0], v[AD_W+BE_W-1:AD_W], 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5 bad");
        end

        // R3: address phase on frame edge
        @(negedge clk);
        frame_n = 1'b0;
        bus_ad  = 32'hDEAD_BEEF;
        bus_cbe = 4'h6;
        @(negedge clk);
        bus_par = ~even_par(32'hDEAD_BEEF, 4'h6);
        bus_ad  = 32'h0;
        @(negedge clk);
        check("R3 address edge", perr_seen, 1);
        clear_flag();
        // R4: frame held low, parity wrong for several cycles
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            bus_ad  = 32'(i * 7);
            bus_par = ~even_par(bus_ad, bus_cbe);
        end
        @(negedge clk);
        check("R4 frame held", perr_seen, 0);
        frame_n = 1'b1;
        @(negedge clk);
        // R3: good parity on address edge
        frame_n = 1'b0;
        bus_ad  = 32'h0F0F_0001;
        @(negedge clk);
        frame_n = 1'b1;
        bus_par = even_par(32'h0F0F_0001, bus_cbe);
        @(negedge clk);
        check("R3 address good", perr_seen, 0);

        // R8: partial writes do not clear
        data_cycle(32'h5, 4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5 set again");
        // data_cycle cleared it; set once more without clearing
        @(negedge clk);
        irdy_n = 1'b0; trdy_n = 1'b0; tgt_hit = 1'b1; bus_ad = 32'h9; bus_cbe = 4'h0;
        @(negedge clk);
        irdy_n = 1'b1; trdy_n = 1'b1; tgt_hit = 1'b0; bus_par = ~even_par(32'h9, 4'h0);
        @(negedge clk);
        check("R8 set", perr_seen, 1);
        stat_wr = 1'b1; stat_w1c = 1'b0;
        @(negedge clk);
        check("R8 write zero", perr_seen, 1);
        stat_wr = 1'b0; stat_w1c = 1'b1;
        @(negedge clk);
        check("R8 no strobe", perr_seen, 1);
        stat_w1c = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 sticky", perr_seen, 1);

        // R9: mismatch and clear on the same edge
        irdy_n = 1'b0; trdy_n = 1'b0; tgt_hit = 1'b1; bus_ad = 32'hA; bus_cbe = 4'h3;
        @(negedge clk);
        irdy_n = 1'b1; trdy_n = 1'b1; tgt_hit = 1'b0; bus_par = ~even_par(32'hA, 4'h3);
        stat_wr = 1'b1; stat_w1c = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0; stat_w1c = 1'b0;
        check("R9 set wins", perr_seen, 1);
        clear_flag();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule